// File: doc/BRIEF.md
# Instruction Decode Stage

This block is the decode stage of a five-stage 32-bit pipeline. It takes an instruction word and its sequential program counter from the fetch stage. It works out the instruction class from the six-bit opcode and pulls out the register specifiers, the function field and the immediate. It reads two operands from a 32-entry register file, and it places the whole decoded bundle in a decode/execute register for the execute stage.

Conditional branches are resolved here, in the same cycle the branch is accepted, so the fetch stage gets its new PC one stage early. The format has no jump encoding. An unconditional jump is a branch-if-zero that tests R0. The hazard logic outside the block can ask for a bubble. The block then loads an all-zero NOP into the execute register and holds the fetch side.

Both data edges use valid/ready. An instruction is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high when the execute register is empty or is being drained (`!out_valid || out_ready`), and no bubble is requested. While `out_valid` is high and `out_ready` is low, the execute register and all `out_*` signals hold their values.

Top module: `id_stage`

## Requirements
- R1: For every instruction, `out_rs1` = instr[25:21], `out_rs2` = instr[20:16] and `out_func` = instr[10:0].
- R2: `out_class` is taken from opcode instr[31:26] as follows. 000000 gives 0 (NOP), 010xxx gives 1 (load), 011xxx gives 2 (store), 100xxx gives 3 (register ALU), 11xxxx gives 4 (immediate ALU), 101xxx gives 5 (flow) and any other opcode gives 6 (reserved).
- R3: `out_dst` is instr[15:11] for class 3 and instr[20:16] for classes 1 and 4. For every other class it is 0.
- R4: `out_imm` is instr[15:0] sign-extended to 32 bits. `out_pc` is the accepted `in_pc`.
- R5: `out_a` holds register rs1 and `out_b` holds register rs2, both read at the accepting edge. R0 always reads as 0, and a write-back to R0 is discarded.
- R6: If write-back writes a register in the same cycle that an accepted instruction reads it, the operand (and the branch test) uses the newly written value.
- R7: A class-5 instruction with opcode bit 26 = 0 is taken when rs1 = 0. With bit 26 = 1 it is taken when rs1 ≠ 0. A taken branch raises `redirect` in the same cycle it is accepted, with `redirect_pc` = `in_pc` + the sign-extended immediate. `redirect` is never high unless an instruction is accepted.
- R8: When `bubble` is high, `in_ready` and `redirect` are low. At the next free edge the execute register loads an all-zero bundle with `out_valid` = 1.
- R9: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and every `out_*` value holds.
- R10: After reset, `out_valid` = 0, `in_ready` = 1 and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word available |
| in_ready | output | 1 | Decode accepts the instruction this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Sequential PC of the instruction |
| bubble | input | 1 | Insert NOP and stall fetch |
| wb_en | input | 1 | Register write-back enable |
| wb_addr | input | 5 | Write-back register index |
| wb_data | input | 32 | Write-back value |
| redirect | output | 1 | Taken branch accepted this cycle |
| redirect_pc | output | 32 | Branch target |
| out_valid | output | 1 | Execute register holds an entry |
| out_ready | input | 1 | Execute stage takes the entry |
| out_class | output | 3 | Instruction class code |
| out_rs1 | output | 5 | First source index |
| out_rs2 | output | 5 | Second source index |
| out_dst | output | 5 | Destination index, 0 if none |
| out_func | output | 11 | Function field |
| out_imm | output | 32 | Sign-extended immediate |
| out_a | output | 32 | Operand from rs1 |
| out_b | output | 32 | Operand from rs2 |
| out_pc | output | 32 | PC carried with the entry |

## Verification
`in_ready`, `redirect` and `redirect_pc` are combinational. They are due in the cycle the instruction is presented, so the bench checks them one time unit after driving, before the next rising edge. Every `out_*` value appears one rising edge after acceptance, and a write-back lands in the file on the edge where it is enabled. The bench drives on the falling edge and checks registered outputs at the following falling edge. The bench sweeps all 64 opcodes and every register index for reads, and covers same-cycle bypass, both branch senses, bubbles and held back-pressure.

// File: rtl/id_pkg.sv
package id_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RA_W   = $clog2(NREG);
  localparam int OP_W   = 6;
  localparam int FUNC_W = 11;
  localparam int IMM_W  = 16;
  localparam int CLS_W  = 3;

  localparam int OP_LSB  = XLEN - OP_W;
  localparam int RS1_LSB = OP_LSB - RA_W;
  localparam int RS2_LSB = RS1_LSB - RA_W;
  localparam int RD_LSB  = RS2_LSB - RA_W;

  typedef enum logic [CLS_W-1:0] {
    CL_NOP   = 3'd0,
    CL_LOAD  = 3'd1,
    CL_STORE = 3'd2,
    CL_ALUR  = 3'd3,
    CL_ALUI  = 3'd4,
    CL_FLOW  = 3'd5,
    CL_RSVD  = 3'd6
  } iclass_e;

  typedef struct packed {
    iclass_e           cls;
    logic [RA_W-1:0]   rs1;
    logic [RA_W-1:0]   rs2;
    logic [RA_W-1:0]   dst;
    logic [FUNC_W-1:0] func;
    logic [XLEN-1:0]   imm;
    logic              br_ne;
  } fields_t;

  typedef struct packed {
    iclass_e           cls;
    logic [RA_W-1:0]   rs1;
    logic [RA_W-1:0]   rs2;
    logic [RA_W-1:0]   dst;
    logic [FUNC_W-1:0] func;
    logic [XLEN-1:0]   imm;
    logic [XLEN-1:0]   a;
    logic [XLEN-1:0]   b;
    logic [XLEN-1:0]   pc;
  } bundle_t;

  function automatic iclass_e class_of(input logic [OP_W-1:0] op);
    iclass_e c;
    if (op == '0)                c = CL_NOP;
    else if (op[5:4] == 2'b11)   c = CL_ALUI;
    else if (op[5:3] == 3'b010)  c = CL_LOAD;
    else if (op[5:3] == 3'b011)  c = CL_STORE;
    else if (op[5:3] == 3'b100)  c = CL_ALUR;
    else if (op[5:3] == 3'b101)  c = CL_FLOW;
    else                         c = CL_RSVD;
    return c;
  endfunction
endpackage

// File: rtl/id_field_decode.sv
module id_field_decode
  import id_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output fields_t         f
);
  logic [OP_W-1:0] op;
  iclass_e         cls;

  assign op  = instr[XLEN-1:OP_LSB];
  assign cls = class_of(op);

  always_comb begin
    f.cls   = cls;
    f.rs1   = instr[RS1_LSB +: RA_W];
    f.rs2   = instr[RS2_LSB +: RA_W];
    f.func  = instr[FUNC_W-1:0];
    f.imm   = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    f.br_ne = op[0];
    unique case (cls)
      CL_ALUR:         f.dst = instr[RD_LSB +: RA_W];
      CL_LOAD, CL_ALUI: f.dst = instr[RS2_LSB +: RA_W];
      default:         f.dst = '0;
    endcase
  end
endmodule

// File: rtl/id_regfile.sv
module id_regfile #(
  parameter int W  = 32,
  parameter int N  = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  assign regs[0] = '0;

  for (genvar i = 1; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[i] <= '0;
      else if (we && waddr == AW'(i))      regs[i] <= wdata;
    end
  end

  // same-cycle write forwarding; index 0 never forwarded
  always_comb begin
    rdata_a = regs[raddr_a];
    rdata_b = regs[raddr_b];
    if (we && waddr != '0 && waddr == raddr_a) rdata_a = wdata;
    if (we && waddr != '0 && waddr == raddr_b) rdata_b = wdata;
  end
endmodule

// File: rtl/id_branch_unit.sv
module id_branch_unit #(
  parameter int W = 32
) (
  input  logic         accept,
  input  logic         is_flow,
  input  logic         on_nonzero,
  input  logic [W-1:0] test_val,
  input  logic [W-1:0] seq_pc,
  input  logic [W-1:0] offset,
  output logic         taken,
  output logic [W-1:0] target
);
  logic is_zero;
  assign is_zero = (test_val == '0);
  assign taken   = accept && is_flow && (on_nonzero ? !is_zero : is_zero);
  assign target  = seq_pc + offset;
endmodule

// File: rtl/id_stage.sv
module id_stage
  import id_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   in_instr,
  input  logic [XLEN-1:0]   in_pc,
  input  logic              bubble,
  input  logic              wb_en,
  input  logic [RA_W-1:0]   wb_addr,
  input  logic [XLEN-1:0]   wb_data,
  output logic              redirect,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CLS_W-1:0]  out_class,
  output logic [RA_W-1:0]   out_rs1,
  output logic [RA_W-1:0]   out_rs2,
  output logic [RA_W-1:0]   out_dst,
  output logic [FUNC_W-1:0] out_func,
  output logic [XLEN-1:0]   out_imm,
  output logic [XLEN-1:0]   out_a,
  output logic [XLEN-1:0]   out_b,
  output logic [XLEN-1:0]   out_pc
);
  fields_t         f;
  logic [XLEN-1:0] op_a, op_b;
  logic            slot_free, take;
  bundle_t         nxt, q;
  logic            q_valid;

  id_field_decode u_dec (.instr(in_instr), .f(f));

  id_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(wb_en), .waddr(wb_addr), .wdata(wb_data),
    .raddr_a(f.rs1), .raddr_b(f.rs2),
    .rdata_a(op_a), .rdata_b(op_b)
  );

  assign slot_free = !q_valid || out_ready;
  assign in_ready  = slot_free && !bubble;
  assign take      = in_valid && in_ready;

  id_branch_unit #(.W(XLEN)) u_br (
    .accept(take), .is_flow(f.cls == CL_FLOW), .on_nonzero(f.br_ne),
    .test_val(op_a), .seq_pc(in_pc), .offset(f.imm),
    .taken(redirect), .target(redirect_pc)
  );

  always_comb begin
    nxt.cls  = f.cls;
    nxt.rs1  = f.rs1;
    nxt.rs2  = f.rs2;
    nxt.dst  = f.dst;
    nxt.func = f.func;
    nxt.imm  = f.imm;
    nxt.a    = op_a;
    nxt.b    = op_b;
    nxt.pc   = in_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else if (slot_free) begin
      if (bubble) begin
        q       <= '0;
        q_valid <= 1'b1;
      end else if (in_valid) begin
        q       <= nxt;
        q_valid <= 1'b1;
      end else begin
        q_valid <= 1'b0;
      end
    end
  end

  assign out_valid = q_valid;
  assign out_class = q.cls;
  assign out_rs1   = q.rs1;
  assign out_rs2   = q.rs2;
  assign out_dst   = q.dst;
  assign out_func  = q.func;
  assign out_imm   = q.imm;
  assign out_a     = q.a;
  assign out_b     = q.b;
  assign out_pc    = q.pc;
endmodule

// File: rtl/id_stage_chk.sv
module id_stage_chk
  import id_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              bubble,
  input logic              redirect,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CLS_W-1:0]  out_class,
  input logic [RA_W-1:0]   out_rs1,
  input logic [RA_W-1:0]   out_rs2,
  input logic [RA_W-1:0]   out_dst,
  input logic [FUNC_W-1:0] out_func,
  input logic [XLEN-1:0]   out_imm,
  input logic [XLEN-1:0]   out_a,
  input logic [XLEN-1:0]   out_b,
  input logic [XLEN-1:0]   out_pc
);
  a_r2_class_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_class != 3'd7);

  a_r3_no_dst: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == 3'd0 || out_class == 3'd2 || out_class == 3'd5 || out_class == 3'd6)
    |-> out_dst == '0);

  a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_rs1 == '0 |-> out_a == '0);

  a_r5_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_rs2 == '0 |-> out_b == '0);

  a_r7_redirect_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> in_valid && in_ready && !bubble);

  a_r8_bubble_stall: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> !in_ready);

  a_r8_bubble_nop: assert property (@(posedge clk) disable iff (!rst_n)
    bubble && (!out_valid || out_ready) |=>
      out_valid && out_class == '0 && out_dst == '0 && out_a == '0 &&
      out_b == '0 && out_imm == '0 && out_pc == '0);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_class) && $stable(out_rs1) && $stable(out_rs2) &&
      $stable(out_dst) && $stable(out_func) && $stable(out_imm) &&
      $stable(out_a) && $stable(out_b) && $stable(out_pc));

  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind id_stage id_stage_chk u_chk (.*);

// File: tb/id_stage_test.sv
`timescale 1ns/1ps
module id_stage_test;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, bubble = 0, wb_en = 0, out_ready = 1;
  logic [31:0] in_instr = 0, in_pc = 0, wb_data = 0;
  logic [4:0]  wb_addr = 0;
  logic        in_ready, redirect, out_valid;
  logic [31:0] redirect_pc, out_imm, out_a, out_b, out_pc;
  logic [2:0]  out_class;
  logic [4:0]  out_rs1, out_rs2, out_dst;
  logic [10:0] out_func;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  id_stage uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] regval(int i);
    return (i == 0) ? 32'h0 : (32'(i) * 32'h0101_0101) ^ 32'hA500_0003;
  endfunction

  function automatic logic [2:0] exp_cls(logic [5:0] op);
    if (op == 0) return 3'd0;
    if (op[5:4] == 2'b11) return 3'd4;
    case (op[5:3])
      3'b010: return 3'd1;
      3'b011: return 3'd2;
      3'b100: return 3'd3;
      3'b101: return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic send(logic [31:0] ins, logic [31:0] pc);
    in_instr = ins; in_pc = pc; in_valid = 1;
    tick();
    in_valid = 0;
  endtask

  task automatic br(string req, logic [31:0] ins, logic [31:0] pc, bit taken, logic [31:0] tgt);
    in_instr = ins; in_pc = pc; in_valid = 1;
    #1;
    check(req, {31'b0, redirect}, {31'b0, taken});
    if (taken) check(req, redirect_pc, tgt);
    @(negedge clk); tick();
    in_valid = 0; wb_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    check("R10 out_valid", {31'b0, out_valid}, 0);
    check("R10 in_ready", {31'b0, in_ready}, 1);
    in_instr = {6'b100000, 5'd9, 5'd17, 5'd1, 11'd0}; in_valid = 1; #1;
    in_valid = 0;
    tick();
    send({6'b100000, 5'd9, 5'd17, 5'd1, 11'd0}, 0);
    check("R10 regs zero a", out_a, 0);
    check("R10 regs zero b", out_b, 0);

    // fill register file; R5: write to R0 ignored
    for (int i = 0; i < 32; i++) begin
      wb_en = 1; wb_addr = 5'(i); wb_data = (i == 0) ? 32'hDEAD_BEEF : regval(i);
      tick();
    end
    wb_en = 0;

    // R1 R3 R5: read sweep over all indices
    for (int i = 0; i < 32; i++) begin
      send({6'b100010, 5'(i), 5'(31 - i), 5'd7, 11'h5A5}, 32'(i));
      check("R5 out_a", out_a, regval(i));
      check("R5 out_b", out_b, regval(31 - i));
      check("R1 rs1", {27'b0, out_rs1}, 32'(i));
      check("R1 rs2", {27'b0, out_rs2}, 32'(31 - i));
      check("R1 func", {21'b0, out_func}, 32'h5A5);
      check("R3 dst alur", {27'b0, out_dst}, 7);
    end

    // R2 R3 R4: opcode sweep
    for (int op = 0; op < 64; op++) begin
      logic [31:0] ins;
      logic [2:0]  c;
      logic [4:0]  d;
      ins = {6'(op), 5'd2, 5'd3, (op[0] ? 16'h8801 : 16'h77FE)};
      c = exp_cls(6'(op));
      d = (c == 3) ? ins[15:11] : ((c == 1 || c == 4) ? ins[20:16] : 5'd0);
      send(ins, 32'h1000 + 32'(op));
      check("R2 class", {29'b0, out_class}, {29'b0, c});
      check("R3 dst", {27'b0, out_dst}, {27'b0, d});
      check("R4 imm", out_imm, {{16{ins[15]}}, ins[15:0]});
      check("R4 pc", out_pc, 32'h1000 + 32'(op));
    end

    // R7: branch resolution
    br("R7 beqz r0 jump", {6'b101000, 5'd0, 5'd0, 16'hFFF0}, 32'h100, 1, 32'h0F0);
    br("R7 bnez r0", {6'b101001, 5'd0, 5'd0, 16'hFFF0}, 32'h100, 0, 0);
    br("R7 bnez r3", {6'b101001, 5'd3, 5'd0, 16'h0040}, 32'h200, 1, 32'h240);
    br("R7 beqz r3", {6'b101000, 5'd3, 5'd0, 16'h0040}, 32'h200, 0, 0);
    br("R7 non-flow", {6'b100000, 5'd0, 5'd0, 16'h0040}, 32'h200, 0, 0);
    // R6: branch sees same-cycle write of zero
    wb_en = 1; wb_addr = 4; wb_data = 0;
    br("R6 R7 bypass beqz", {6'b101000, 5'd4, 5'd0, 16'h0008}, 32'h300, 1, 32'h308);

    // R6: operand bypass
    in_instr = {6'b100000, 5'd5, 5'd5, 16'h0}; in_pc = 0; in_valid = 1;
    wb_en = 1; wb_addr = 5; wb_data = 32'h1234_5678;
    tick(); in_valid = 0; wb_en = 0;
    check("R6 bypass a", out_a, 32'h1234_5678);
    check("R6 bypass b", out_b, 32'h1234_5678);
    // R5: R0 stays zero even with simultaneous write
    in_instr = {6'b100000, 5'd0, 5'd0, 16'h0}; in_valid = 1;
    wb_en = 1; wb_addr = 0; wb_data = 32'hFFFF_FFFF;
    tick(); in_valid = 0; wb_en = 0;
    check("R5 r0 write", out_a, 0);

    // R8: bubble
    in_instr = {6'b101000, 5'd0, 5'd0, 16'h0010}; in_pc = 32'h400; in_valid = 1; bubble = 1;
    #1;
    check("R8 in_ready low", {31'b0, in_ready}, 0);
    check("R8 no redirect", {31'b0, redirect}, 0);
    @(negedge clk); tick();
    check("R8 valid", {31'b0, out_valid}, 1);
    check("R8 class", {29'b0, out_class}, 0);
    check("R8 pc", out_pc, 0);
    check("R8 imm", out_imm, 0);
    bubble = 0;
    tick(); in_valid = 0;
    check("R8 resume", {29'b0, out_class}, 5);
    check("R8 resume pc", out_pc, 32'h400);

    // R9: back-pressure
    send({6'b100000, 5'd3, 5'd6, 16'h0}, 32'h55);
    out_ready = 0;
    in_instr = {6'b110000, 5'd7, 5'd8, 16'h1234}; in_pc = 32'h66; in_valid = 1;
    #1;
    check("R9 in_ready", {31'b0, in_ready}, 0);
    @(negedge clk); tick();
    check("R9 hold pc", out_pc, 32'h55);
    check("R9 hold a", out_a, regval(3));
    out_ready = 1;
    tick(); in_valid = 0;
    check("R9 next pc", out_pc, 32'h66);
    check("R9 next class", {29'b0, out_class}, 4);
    tick();
    check("R9 drained", {31'b0, out_valid}, 0);

    finish_run();
  end
endmodule